// File: doc/BRIEF.md
# Pulse Width Symbol Classifier

This block decodes a self-clocked serial line without a bit clock. It times each high and each low stretch of the line in ticks, then sorts the measured length into one of four symbol classes or an error class. The four classes are a short data interval, a long data interval, a 1.5-unit sync interval and a 2.0-unit sync interval. Each class has its own inclusive window of tick counts, supplied on input ports, so edge jitter of a few ticks is absorbed. With a 32 MHz tick the usual windows are 14..18, 30..34, 46..50 and 62..66.

For every edge after the first, the block issues a one-cycle strobe with the class code and the polarity of the interval that just ended. A small controller has three states. OFF is entered at reset and whenever `enable` is low. OFF goes to ARM when `enable` rises. ARM goes to RUN on the first edge, which only starts timing. RUN emits a symbol on every edge. ARM and RUN both return to OFF when `enable` falls. Assembling symbols into bytes or frames is left to the consumer.

Top module: `pulse_symbol_classifier`

## Requirements
- R1: An interval whose tick count lies in [short_lo, short_hi] is reported with class code 3'd0.
- R2: An interval whose count lies in [long_lo, long_hi] and not in the short window is reported with code 3'd1.
- R3: An interval whose count lies in [synca_lo, synca_hi] and in no earlier window is reported with code 3'd2.
- R4: An interval whose count lies in [syncb_lo, syncb_hi] and in no earlier window is reported with code 3'd3.
- R5: An interval that matches no window is reported with code 3'd7. This includes intervals shorter than every window and intervals falling between windows.
- R6: Window bounds are inclusive. A count equal to lo or hi is accepted, and lo-1 or hi+1 is not.
- R7: sym_level is 1 for an interval during which the line was high (rise to fall) and 0 for a low interval (fall to rise).
- R8: The first edge after reset, and the first edge after enable rises, produce no strobe. While enable is low, no strobe is produced and edges are ignored.
- R9: The interval counter stops at 2^CNT_W-1. An interval that reaches that count is reported as code 3'd7, even when a window covers the count.
- R10: sym_valid is high for exactly one cycle per classified edge.
- R11: Windows follow their input ports at run time. Where windows overlap, the lower code wins.
- R12: The counter advances only in cycles where tick_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Classifier enable; low forces OFF |
| tick_en | input | 1 | Time-base tick, one count per high cycle |
| line_in | input | 1 | Asynchronous serial line |
| short_lo | input | CNT_W | Short data window, lower bound |
| short_hi | input | CNT_W | Short data window, upper bound |
| long_lo | input | CNT_W | Long data window, lower bound |
| long_hi | input | CNT_W | Long data window, upper bound |
| synca_lo | input | CNT_W | 1.5-unit sync window, lower bound |
| synca_hi | input | CNT_W | 1.5-unit sync window, upper bound |
| syncb_lo | input | CNT_W | 2.0-unit sync window, lower bound |
| syncb_hi | input | CNT_W | 2.0-unit sync window, upper bound |
| sym_valid | output | 1 | One-cycle symbol strobe |
| sym_class | output | 3 | Class code (0, 1, 2, 3 or 7) |
| sym_level | output | 1 | Polarity of the finished interval |

## Verification
The bench builds the block with CNT_W = 7 and SYNC_STAGES = 2. The 7-bit counter saturates at 127 ticks, so the bench can reach saturation in a short run. The same width still holds all four usual windows, and the bench can program a window that reaches the saturation count. The bench drives tick_en high on every cycle, and in one section on alternate cycles, so it sets interval lengths exactly in clock cycles. Every window edge and every gap between windows is probed this way.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        SYM_SHORT  = 3'd0,
        SYM_LONG   = 3'd1,
        SYM_SYNC_A = 3'd2,
        SYM_SYNC_B = 3'd3,
        SYM_ERR    = 3'd7
    } sym_code_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARM,
        ST_RUN
    } psc_state_e;

    localparam int unsigned NUM_WIN = 4;

endpackage

// File: rtl/psc_line_sync.sv
module psc_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic prev_o,
    output logic edge_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain[0] <= line_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], line_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_o <= 1'b0;
        else        prev_o <= chain[STAGES-1];
    end

    assign edge_o = chain[STAGES-1] ^ prev_o;

endmodule

// File: rtl/psc_interval_timer.sv
module psc_interval_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             restart_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_o <= '0;
        else if (clear_i)
            count_o <= '0;
        else if (restart_i)
            count_o <= tick_i ? CNT_W'(1) : '0;
        else if (tick_i && (count_o != CNT_MAX))
            count_o <= count_o + 1'b1;
    end

    assign sat_o = (count_o == CNT_MAX);

    // R9: once at the limit, the count holds there until an edge or a clear
    assert_sat_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX && !clear_i && !restart_i) |=> (count_o == CNT_MAX));

    // R12: without a tick the count does not move
    assert_no_tick_hold_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !restart_i && !tick_i) |=> $stable(count_o));

endmodule

// File: rtl/psc_window_match.sv
module psc_window_match
    import psc_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned NUM   = NUM_WIN
) (
    input  logic [CNT_W-1:0]          count_i,
    input  logic                      sat_i,
    input  logic [NUM-1:0][CNT_W-1:0] lo_i,
    input  logic [NUM-1:0][CNT_W-1:0] hi_i,
    output sym_code_e                 code_o
);
    logic [NUM-1:0] hit;

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_win
            assign hit[g] = (count_i >= lo_i[g]) && (count_i <= hi_i[g]);
        end
    endgenerate

    always_comb begin
        code_o = SYM_ERR;
        if (!sat_i) begin
            for (int i = NUM - 1; i >= 0; i--) begin
                if (hit[i]) code_o = sym_code_e'(3'(i));
            end
        end
    end

endmodule

// File: rtl/pulse_symbol_classifier.sv
module pulse_symbol_classifier
    import psc_pkg::*;
#(
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick_en,
    input  logic             line_in,
    input  logic [CNT_W-1:0] short_lo,
    input  logic [CNT_W-1:0] short_hi,
    input  logic [CNT_W-1:0] long_lo,
    input  logic [CNT_W-1:0] long_hi,
    input  logic [CNT_W-1:0] synca_lo,
    input  logic [CNT_W-1:0] synca_hi,
    input  logic [CNT_W-1:0] syncb_lo,
    input  logic [CNT_W-1:0] syncb_hi,
    output logic             sym_valid,
    output logic [2:0]       sym_class,
    output logic             sym_level
);
    psc_state_e state, state_nx;

    logic             line_prev;
    logic             line_edge;
    logic             tmr_clear;
    logic [CNT_W-1:0] tmr_count;
    logic             tmr_sat;
    sym_code_e        match_code;
    logic             emit;

    logic [NUM_WIN-1:0][CNT_W-1:0] win_lo;
    logic [NUM_WIN-1:0][CNT_W-1:0] win_hi;

    assign win_lo = {syncb_lo, synca_lo, long_lo, short_lo};
    assign win_hi = {syncb_hi, synca_hi, long_hi, short_hi};

    psc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .prev_o  (line_prev),
        .edge_o  (line_edge)
    );

    assign tmr_clear = !enable || (state == ST_OFF);

    psc_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmr_clear),
        .restart_i (line_edge),
        .tick_i    (tick_en),
        .count_o   (tmr_count),
        .sat_o     (tmr_sat)
    );

    psc_window_match #(.CNT_W(CNT_W), .NUM(NUM_WIN)) u_match (
        .count_i (tmr_count),
        .sat_i   (tmr_sat),
        .lo_i    (win_lo),
        .hi_i    (win_hi),
        .code_o  (match_code)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (enable) state_nx = ST_ARM;
            ST_ARM: begin
                if (!enable)        state_nx = ST_OFF;
                else if (line_edge) state_nx = ST_RUN;
            end
            ST_RUN: if (!enable) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    assign emit = (state == ST_RUN) && enable && line_edge;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_valid <= 1'b0;
            sym_class <= 3'd0;
            sym_level <= 1'b0;
        end else begin
            sym_valid <= emit;
            if (emit) begin
                sym_class <= match_code;
                sym_level <= line_prev;
            end
        end
    end

    // R5: only the five defined codes ever leave the block
    assert_code_legal_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_class inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7}));

    // R8: a low enable blocks the strobe in the following cycle
    assert_quiet_off_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sym_valid);

    // R8: the arming edge never yields a symbol
    assert_arm_silent_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |=> !sym_valid);

    // R9: a saturated count at an edge becomes an error symbol
    assert_sat_error_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (emit && tmr_sat) |=> (sym_valid && sym_class == 3'd7));

endmodule

// File: tb/tb_pulse_symbol_classifier.sv
`timescale 1ns/1ps
module tb_pulse_symbol_classifier;
    localparam int CW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic tick_en = 1'b1;
    logic line_in = 1'b0;
    logic [CW-1:0] short_lo = 7'd14, short_hi = 7'd18;
    logic [CW-1:0] long_lo  = 7'd30, long_hi  = 7'd34;
    logic [CW-1:0] synca_lo = 7'd46, synca_hi = 7'd50;
    logic [CW-1:0] syncb_lo = 7'd62, syncb_hi = 7'd66;
    logic sym_valid;
    logic [2:0] sym_class;
    logic sym_level;

    pulse_symbol_classifier #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick_en(tick_en), .line_in(line_in),
        .short_lo(short_lo), .short_hi(short_hi), .long_lo(long_lo), .long_hi(long_hi),
        .synca_lo(synca_lo), .synca_hi(synca_hi), .syncb_lo(syncb_lo), .syncb_hi(syncb_hi),
        .sym_valid(sym_valid), .sym_class(sym_class), .sym_level(sym_level)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_code [64];
    int exp_lvl  [64];
    int got_code [64];
    int got_lvl  [64];
    int n_exp = 0;
    int n_got = 0;
    int dbl_valid = 0;
    bit prev_v = 1'b0;
    bit tick_alt = 1'b0;

    // interval length in cycles, expected code; bounds rows probe R6
    localparam int VEC_N = 23;
    localparam int VEC_LEN  [VEC_N] = '{16, 14, 18, 13, 19, 32, 30, 34, 29, 35,
                                        48, 46, 50, 45, 51, 64, 62, 66, 61, 67,
                                        5, 100, 200};
    localparam int VEC_CODE [VEC_N] = '{0, 0, 0, 7, 7, 1, 1, 1, 7, 7,
                                        2, 2, 2, 7, 7, 3, 3, 3, 7, 7,
                                        7, 7, 7};

    always @(negedge clk) begin
        if (rst_n) begin
            if (sym_valid) begin
                if (n_got < 64) begin
                    got_code[n_got] = int'(sym_class);
                    got_lvl[n_got]  = int'(sym_level);
                end
                n_got++;
                if (prev_v) dbl_valid++;
            end
            prev_v = sym_valid;
        end
    end

    always @(negedge clk) tick_en = tick_alt ? ~tick_en : 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int code);
        case (code)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic hold_flip(input int d, input int code, input bit expect_out);
        repeat (d) @(negedge clk);
        if (expect_out) begin
            exp_code[n_exp] = code;
            exp_lvl[n_exp]  = int'(line_in);
            n_exp++;
        end
        line_in = ~line_in;
    endtask

    task automatic resync();
        hold_flip(150, 7, 1'b1);  // long gap is always an error
    endtask

    task automatic settle_compare(input string req);
        repeat (10) @(negedge clk);
        check(n_got == n_exp, req, "symbol count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(got_code[i] == exp_code[i], req_of(exp_code[i]), "class", got_code[i], exp_code[i]);
            check(got_lvl[i] == exp_lvl[i], "R7", "level", got_lvl[i], exp_lvl[i]);
        end
        n_got = 0;
        n_exp = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sym_valid == 1'b0, "R8", "reset valid", int'(sym_valid), 0);
        enable = 1'b1;
        repeat (3) @(negedge clk);

        // table: first flip arms only (R8), then every row is one interval
        hold_flip(5, 0, 1'b0);
        for (int v = 0; v < VEC_N; v++) hold_flip(VEC_LEN[v], VEC_CODE[v], 1'b1);
        settle_compare("R8");

        // R8: disabled edges are ignored, then re-arm on first edge
        enable = 1'b0;
        hold_flip(20, 0, 1'b0);
        hold_flip(30, 0, 1'b0);
        hold_flip(40, 0, 1'b0);
        settle_compare("R8");
        enable = 1'b1;
        hold_flip(50, 0, 1'b0);
        hold_flip(16, 0, 1'b1);
        settle_compare("R8");

        // R12: ticks on alternate cycles halve the count
        tick_alt = 1'b1;
        resync();
        hold_flip(32, 0, 1'b1);
        hold_flip(64, 1, 1'b1);
        hold_flip(96, 2, 1'b1);
        settle_compare("R12");
        tick_alt = 1'b0;

        // R11: reprogrammed, overlapping windows; lower code wins
        short_lo = 7'd20; short_hi = 7'd24;
        long_lo  = 7'd20; long_hi  = 7'd40;
        resync();
        hold_flip(22, 0, 1'b1);
        hold_flip(16, 7, 1'b1);
        hold_flip(30, 1, 1'b1);
        settle_compare("R11");
        short_lo = 7'd14; short_hi = 7'd18;
        long_lo  = 7'd30; long_hi  = 7'd34;

        // R9: window reaching the limit; saturated count is still an error
        syncb_lo = 7'd60; syncb_hi = 7'd127;
        resync();
        hold_flip(126, 3, 1'b1);
        hold_flip(127, 7, 1'b1);
        hold_flip(300, 7, 1'b1);
        settle_compare("R9");

        // R10: no strobe ever lasted two cycles
        check(dbl_valid == 0, "R10", "multi-cycle strobes", dbl_valid, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule